// File: doc/BRIEF.md
# Warm Reset Sequencer

This block gathers every cause of a warm (manual) restart of the processor core and turns them into one reset event. Three sources can start that event: a falling edge on an asynchronous active-low external restart pin, an exception taken while the status register's block bit is set (user-break exceptions excluded), and a request from the watchdog when watchdog mode is active and its reset-type select asks for a warm reset. A power-on reset request in the same cycle overrides all of them.

When an event is accepted, the block asserts, for exactly one clock cycle, a write strobe and a value for each piece of architectural state that a warm restart redefines. The exception code register receives 0x0000_0020 and the vector base register receives zero. The status register's privileged-mode, bank-select and block bits are set, its floating-point-disable bit is cleared, and its interrupt mask is set to all ones. The program counter receives 0xA000_0000. A peripheral warm-reset pulse and a `reset_taken` marker share that same cycle. The block carries no data stream, so all of its pins are plain control and status with no valid/ready handshake. Callers must accept the one-cycle load whenever it occurs.

Top module: `warm_reset_seq`

## Requirements
- R1: The external pin `mrst_pin_n` passes through a two-flop synchronizer, and only its high-to-low transition creates an event. A pin that is first sampled low at posedge k produces `reset_taken` high after posedge k+2. A pin held low for any length of time produces exactly one event.
- R2: When `exc_taken`=1, `exc_user_break`=0 and `sr_block`=1 are sampled at a posedge, `reset_taken` is high for the following cycle.
- R3: An exception with `sr_block`=0, or one with `exc_user_break`=1, starts no event.
- R4: When `wdt_overflow`=1, `wdt_mode`=1 and `wdt_rst_sel`=1 are sampled at a posedge, an event follows in the next cycle. If `wdt_mode`=0 or `wdt_rst_sel`=0, there is no event.
- R5: During the event cycle, `expevt_we`=1 and `expevt_val`=32'h0000_0020.
- R6: During the event cycle, `vbr_we`=1 and `vbr_val`=32'h0000_0000.
- R7: During the event cycle, `sr_we`=1, `sr_md`=1, `sr_rb`=1, `sr_bl`=1, `sr_fd`=0 and `sr_imask`=4'b1111.
- R8: During the event cycle, `pc_we`=1 and `pc_val`=32'hA000_0000.
- R9: `reset_taken`, `periph_mrst` and all four write strobes rise and fall together for exactly that one cycle. Outside the event cycle, every output, the values included, is zero.
- R10: If `por_req`=1 in the cycle a trigger is sampled, no event follows.
- R11: Triggers from several sources in the same cycle give a single one-cycle event.
- R12: While `rst_n` is low, and after it is released with no trigger, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| mrst_pin_n | input | 1 | Asynchronous external warm-restart pin, active low |
| exc_taken | input | 1 | Strobe: a general exception is being taken |
| exc_user_break | input | 1 | Qualifier: the exception is a user break |
| sr_block | input | 1 | Current status-register block bit |
| wdt_overflow | input | 1 | Strobe: watchdog counter overflow |
| wdt_mode | input | 1 | Watchdog mode selected (not interval mode) |
| wdt_rst_sel | input | 1 | Reset-type select: 1 requests a warm reset |
| por_req | input | 1 | Power-on reset request, takes priority |
| reset_taken | output | 1 | One-cycle marker of the warm reset event |
| periph_mrst | output | 1 | One-cycle peripheral warm-reset pulse |
| expevt_we | output | 1 | Exception code register write strobe |
| expevt_val | output | 32 | Exception code value |
| vbr_we | output | 1 | Vector base register write strobe |
| vbr_val | output | 32 | Vector base value |
| sr_we | output | 1 | Status register field write strobe |
| sr_md | output | 1 | Privileged-mode bit value |
| sr_rb | output | 1 | Register bank bit value |
| sr_bl | output | 1 | Block bit value |
| sr_fd | output | 1 | FPU-disable bit value |
| sr_imask | output | 4 | Interrupt mask value |
| pc_we | output | 1 | Program counter write strobe |
| pc_val | output | 32 | Restart address |

## Verification
A stuck or skipped synchronizer stage shows up as a pin event one cycle early or late. A broken edge detector shows up as repeated events during a long low phase. Both are visible within three cycles of the pin falling. A wrong qualifier in the trigger merge, or a missing power-on override, shows at the port the very next cycle, as a missing or extra `reset_taken`. Any corrupted load value or strobe can be seen only during the single event cycle, because every output is zero outside it.

// File: rtl/wrst_pkg.sv
package wrst_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IMASK_W  = 4;

  localparam logic [WORD_W-1:0]  EXC_CODE_WARM = 32'h0000_0020;
  localparam logic [WORD_W-1:0]  VBR_WARM      = 32'h0000_0000;
  localparam logic [WORD_W-1:0]  PC_WARM       = 32'hA000_0000;
  localparam logic [IMASK_W-1:0] IMASK_WARM    = '1;

  typedef struct packed {
    logic               md;
    logic               rb;
    logic               bl;
    logic               fd;
    logic [IMASK_W-1:0] imask;
  } sr_fields_t;

  localparam sr_fields_t SR_WARM = '{md: 1'b1, rb: 1'b1, bl: 1'b1, fd: 1'b0, imask: IMASK_WARM};
endpackage

// File: rtl/wrst_pin_sync.sv
module wrst_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[LAST];
  end

  assign fall = prev_q & ~sync_q[LAST];

  // R1: a falling edge is reported for a single cycle only
  assert_single_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/wrst_arbiter.sv
module wrst_arbiter (
  input  logic pin_fall,
  input  logic exc_taken,
  input  logic exc_user_break,
  input  logic sr_block,
  input  logic wdt_overflow,
  input  logic wdt_mode,
  input  logic wdt_rst_sel,
  input  logic por_req,
  output logic fire
);
  logic exc_trig;
  logic wdt_trig;

  always_comb begin
    exc_trig = exc_taken & ~exc_user_break & sr_block;
    wdt_trig = wdt_overflow & wdt_mode & wdt_rst_sel;
    fire     = (pin_fall | exc_trig | wdt_trig) & ~por_req;
  end
endmodule

// File: rtl/wrst_state_load.sv
module wrst_state_load
  import wrst_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  output logic                load,
  output logic [WORD_W-1:0]   expevt_val,
  output logic [WORD_W-1:0]   vbr_val,
  output sr_fields_t          sr_val,
  output logic [WORD_W-1:0]   pc_val
);
  logic load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= fire;
  end

  assign load = load_q;

  always_comb begin
    expevt_val = load_q ? EXC_CODE_WARM : '0;
    vbr_val    = load_q ? VBR_WARM      : '0;
    sr_val     = load_q ? SR_WARM       : '0;
    pc_val     = load_q ? PC_WARM       : '0;
  end
endmodule

// File: rtl/warm_reset_seq.sv
module warm_reset_seq
  import wrst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mrst_pin_n,
  input  logic               exc_taken,
  input  logic               exc_user_break,
  input  logic               sr_block,
  input  logic               wdt_overflow,
  input  logic               wdt_mode,
  input  logic               wdt_rst_sel,
  input  logic               por_req,
  output logic               reset_taken,
  output logic               periph_mrst,
  output logic               expevt_we,
  output logic [WORD_W-1:0]  expevt_val,
  output logic               vbr_we,
  output logic [WORD_W-1:0]  vbr_val,
  output logic               sr_we,
  output logic               sr_md,
  output logic               sr_rb,
  output logic               sr_bl,
  output logic               sr_fd,
  output logic [IMASK_W-1:0] sr_imask,
  output logic               pc_we,
  output logic [WORD_W-1:0]  pc_val
);
  logic       pin_fall;
  logic       fire;
  logic       load;
  sr_fields_t sr_val;

  wrst_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (mrst_pin_n),
    .fall  (pin_fall)
  );

  wrst_arbiter u_arb (
    .pin_fall       (pin_fall),
    .exc_taken      (exc_taken),
    .exc_user_break (exc_user_break),
    .sr_block       (sr_block),
    .wdt_overflow   (wdt_overflow),
    .wdt_mode       (wdt_mode),
    .wdt_rst_sel    (wdt_rst_sel),
    .por_req        (por_req),
    .fire           (fire)
  );

  wrst_state_load u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .load       (load),
    .expevt_val (expevt_val),
    .vbr_val    (vbr_val),
    .sr_val     (sr_val),
    .pc_val     (pc_val)
  );

  assign reset_taken = load;
  assign periph_mrst = load;
  assign expevt_we   = load;
  assign vbr_we      = load;
  assign sr_we       = load;
  assign pc_we       = load;
  assign sr_md       = sr_val.md;
  assign sr_rb       = sr_val.rb;
  assign sr_bl       = sr_val.bl;
  assign sr_fd       = sr_val.fd;
  assign sr_imask    = sr_val.imask;

  // R2: blocked non-break exception forces the event next cycle
  assert_exc_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && !exc_user_break && sr_block && !por_req) |=> reset_taken);

  // R3: a lone user-break exception never triggers
  assert_ubreak_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_user_break && !pin_fall && !wdt_overflow) |=> !reset_taken);

  // R4: watchdog warm-reset request forces the event next cycle
  assert_wdt_trig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_overflow && wdt_mode && wdt_rst_sel && !por_req) |=> reset_taken);

  // R10: power-on request suppresses the following load
  assert_por_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> !reset_taken);

  // R8: restart address present exactly with its strobe
  assert_pc_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (pc_val == PC_WARM && sr_imask == IMASK_WARM));
endmodule

// File: tb/tb_warm_reset_seq.sv
module tb_warm_reset_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrst_pin_n = 1'b1;
  logic        exc_taken = 1'b0, exc_user_break = 1'b0, sr_block = 1'b0;
  logic        wdt_overflow = 1'b0, wdt_mode = 1'b0, wdt_rst_sel = 1'b0;
  logic        por_req = 1'b0;
  logic        reset_taken, periph_mrst, expevt_we, vbr_we, sr_we, pc_we;
  logic [31:0] expevt_val, vbr_val, pc_val;
  logic        sr_md, sr_rb, sr_bl, sr_fd;
  logic [3:0]  sr_imask;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  logic        m1 = 1'b1, m2 = 1'b1, m3 = 1'b1;
  logic        exp_pulse = 1'b0;
  string       exp_tag = "R12";

  always #5 clk = ~clk;

  warm_reset_seq dut (
    .clk(clk), .rst_n(rst_n), .mrst_pin_n(mrst_pin_n), .exc_taken(exc_taken),
    .exc_user_break(exc_user_break), .sr_block(sr_block), .wdt_overflow(wdt_overflow),
    .wdt_mode(wdt_mode), .wdt_rst_sel(wdt_rst_sel), .por_req(por_req),
    .reset_taken(reset_taken), .periph_mrst(periph_mrst), .expevt_we(expevt_we),
    .expevt_val(expevt_val), .vbr_we(vbr_we), .vbr_val(vbr_val), .sr_we(sr_we),
    .sr_md(sr_md), .sr_rb(sr_rb), .sr_bl(sr_bl), .sr_fd(sr_fd), .sr_imask(sr_imask),
    .pc_we(pc_we), .pc_val(pc_val)
  );

  function automatic logic trig(input logic fall, input logic e, input logic ub,
      input logic bl, input logic w, input logic wm, input logic rs, input logic por);
    return (fall | (e & ~ub & bl) | (w & wm & rs)) & ~por;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic check_outputs();
    chk({exp_tag, " reset_taken"}, {31'd0, reset_taken}, {31'd0, exp_pulse});
    if (exp_pulse) begin
      chk("R5 expevt", expevt_val, 32'h0000_0020);
      chk("R6 vbr", vbr_val, 32'h0);
      chk("R7 sr", {23'd0, sr_md, sr_rb, sr_bl, sr_fd, sr_imask}, {23'd0, 4'b1110, 4'hF});
      chk("R8 pc", pc_val, 32'hA000_0000);
      chk("R9 strobes", {26'd0, periph_mrst, expevt_we, vbr_we, sr_we, pc_we, reset_taken},
          32'h3F);
    end else begin
      chk("R9 idle", {periph_mrst, expevt_we, vbr_we, sr_we, pc_we, sr_md, sr_rb, sr_bl,
          sr_fd, sr_imask, 15'd0} | expevt_val | vbr_val | pc_val, 32'h0);
    end
  endtask

  task automatic step(input logic pin, input logic e, input logic ub, input logic bl,
      input logic w, input logic wm, input logic rs, input logic por, input string tag);
    logic fall;
    @(negedge clk);
    check_outputs();
    mrst_pin_n = pin; exc_taken = e; exc_user_break = ub; sr_block = bl;
    wdt_overflow = w; wdt_mode = wm; wdt_rst_sel = rs; por_req = por;
    fall = m3 & ~m2;
    exp_pulse = trig(fall, e, ub, bl, w, wm, rs, por);
    exp_tag = tag;
    m3 = m2; m2 = m1; m1 = pin;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(mrst_pin_n, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    chk("R12 reset outputs", {26'd0, reset_taken, periph_mrst, expevt_we, vbr_we, sr_we, pc_we}
        | pc_val | expevt_val, 32'h0);
    rst_n = 1'b1;
    idle(3, "R12");
    // R2 directed
    step(1, 1, 0, 1, 0, 0, 0, 0, "R2");
    idle(2, "R2");
    // R3: BL clear, then user break
    step(1, 1, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 1, 1, 0, 0, 0, 0, "R3");
    idle(2, "R3");
    // R4: full request, then each qualifier missing
    step(1, 0, 0, 0, 1, 1, 1, 0, "R4");
    step(1, 0, 0, 0, 1, 1, 0, 0, "R4");
    step(1, 0, 0, 0, 1, 0, 1, 0, "R4");
    idle(2, "R4");
    // R1: pin held low a long time, then released
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    idle(12, "R1");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    idle(4, "R1");
    // R10: power-on overrides every trigger
    step(1, 1, 0, 1, 1, 1, 1, 1, "R10");
    idle(2, "R10");
    // R11: all sources together, including a pin edge arriving at the same time
    step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
    step(0, 1, 0, 1, 1, 1, 1, 0, "R11");
    idle(3, "R11");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
    idle(4, "R1");
    // constrained random phase
    for (int k = 0; k < 3000; k++) begin
      logic pin;
      pin = ($urandom_range(0, 15) == 0) ? ~mrst_pin_n : mrst_pin_n;
      step(pin, ($urandom_range(0, 7) == 0), $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 7) == 0), $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 15) == 0), "R11");
    end
    idle(4, "R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule